// File: doc/BRIEF.md
# Pairwise-Tree Reversible-Cell Multiplier

This block multiplies two unsigned N-bit operands, where N is a power of two (default 4). Every primitive is a reversible cell. A grid of N x N controlled-swap cells forms all partial-product bits in one cell delay, because each swap cell with a constant-zero data input yields the AND of its two live inputs. Row j holds the multiplicand gated by multiplier bit j and carries a weight of 2^j. The rows are then reduced two at a time in a balanced tree of ripple adders. Each adder is a chain of one-through four-in/four-out reversible cells, and each of those cells acts as a full adder when its third input is held at zero. The tree has log2 N levels and N-1 adders, so for N = 4 two first-level adders feed one second-level adder that yields the 8-bit product.

Each adder level ends in a register bank with its own enable. A level whose work is done can be left idle, and its register keeps its last contents. A freshness chain tracks whether each level holds data derived from the current operands, and the product is flagged valid only when that chain reaches the last level. Every cell output that no later stage consumes leaves the block on a garbage bus, so nothing inside the tree is silently discarded.

Top module: `mulred_tree`

## Requirements
- R1: While rst_n is low, product reads 0 and product_valid reads 0. Directly after release, product_valid stays 0 until a level has captured.
- R2: With every bit of lvl_en high, once the operands have been held for log2 N rising clock edges, product equals op_a*op_b and product_valid is 1. This holds for every operand pair.
- R3: With every bit of lvl_en high, after an operand change product_valid is still 0 after one edge for N=4 and becomes 1 after the second edge.
- R4: In any cycle where op_a or op_b differs from the value sampled at the previous edge, product_valid is 0 in that same cycle.
- R5: When bit k of lvl_en is low, the registers of adder level k keep their contents. With the last level off, product does not change even if the operands change.
- R6: Level k only becomes current by capturing while level k-1 is already current. Enabling levels out of order (the last level first) does not raise product_valid. Once level 0 and then the last level have each captured, product_valid rises with the correct product.
- R7: The adder cell maps its inputs (a,b,c,d) to outputs (p,q,r,s) as a bijection over all 16 patterns. With c=0 it gives p=a, q=a^b, r=a^b^d (sum) and s=majority(a,b,d) (carry).
- R8: The swap cell maps (ctl,x,y) to (ctl, ctl?y:x, ctl?x:y) as a bijection over all 8 patterns. With y=0 its third output is x AND ctl.
- R9: The first 2*N*N garbage bits belong to the swap grid. For cell k = j*N+i, bit 2k equals op_b[j] and bit 2k+1 equals op_a[i] AND NOT op_b[j]. Above these, each adder level in turn places two bits per adder cell (p then q). Every level above the first also places one provably-zero top carry per adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | N | Multiplicand |
| op_b | input | N | Multiplier |
| lvl_en | input | log2 N | Capture enable, one bit per adder level (bit 0 = first level) |
| product | output | 2N | Registered output of the last adder level |
| product_valid | output | 1 | Product reflects the current operands |
| garbage | output | GW | Unused reversible-cell outputs (48+13=61 bits for N=4) |

## Verification
Several properties are checked on every cycle. A valid flag always comes with the exact product. An operand change always clears the valid flag at once. A disabled last level freezes the product. Valid can only rise right after the last level was enabled. Reset clears both outputs. Some behaviour can only be shown by the directed scenarios: the reversible cells are bijections with the full-adder and AND mappings, the product is correct for all 256 operand pairs, latency is exactly two edges, level enables interact in order, and the garbage bus has its layout.

// File: rtl/mulred_pkg.sv
package mulred_pkg;

   // adder width (and node input width) of tree level l
   function automatic int add_w(input int n, input int l);
      return (l == 0) ? n : n + (1 << l);
   endfunction

   // width of one partial sum produced by level l
   function automatic int out_w(input int n, input int l);
      return n + (1 << (l + 1));
   endfunction

   // number of adders in level l
   function automatic int nodes(input int n, input int l);
      return n >> (l + 1);
   endfunction

   // garbage bits of one adder in level l (two per cell, plus dropped carry above level 0)
   function automatic int node_gw(input int n, input int l);
      return 2 * add_w(n, l) + ((l == 0) ? 0 : 1);
   endfunction

   // garbage bus offset of level l; with l = number of levels it is the bus width
   function automatic int gb_off(input int n, input int l);
      int acc;
      acc = 2 * n * n;
      for (int k = 0; k < l; k++) acc += nodes(n, k) * node_gw(n, k);
      return acc;
   endfunction

endpackage

// File: rtl/rev_swap_cell.sv
module rev_swap_cell (
   input  logic ctl,
   input  logic x,
   input  logic y,
   output logic c_o,
   output logic q_o,
   output logic r_o
);
   assign c_o = ctl;
   assign q_o = ctl ? y : x;
   assign r_o = ctl ? x : y;
endmodule

// File: rtl/rev_fa_cell.sv
module rev_fa_cell (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   output logic p,
   output logic q,
   output logic r,
   output logic s
);
   logic t;
   assign t = (~a & ~c) ^ ~b;
   assign p = a;
   assign q = t;
   assign r = t ^ d;
   assign s = (t & d) ^ ((a & b) ^ c);
endmodule

// File: rtl/pp_gen.sv
module pp_gen #(
   parameter int N = 4
) (
   input  logic [N-1:0]     a,
   input  logic [N-1:0]     b,
   output logic [N*N-1:0]   rows,
   output logic [2*N*N-1:0] junk
);
   if (N < 1) begin : g_bad
      $error("pp_gen: N must be positive");
   end

   for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar i = 0; i < N; i++) begin : g_bit
         localparam int K = j * N + i;
         rev_swap_cell u_sw (
            .ctl (b[j]),
            .x   (a[i]),
            .y   (1'b0),
            .c_o (junk[2*K]),
            .q_o (junk[2*K+1]),
            .r_o (rows[K])
         );
      end
   end
endmodule

// File: rtl/rev_ripple_add.sv
module rev_ripple_add #(
   parameter int W = 4
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [W-1:0]   sum,
   output logic           cout,
   output logic [2*W-1:0] junk
);
   if (W < 1) begin : g_bad
      $error("rev_ripple_add: W must be positive");
   end

   logic [W:0] cy;
   assign cy[0] = 1'b0;

   for (genvar i = 0; i < W; i++) begin : g_cell
      rev_fa_cell u_fa (
         .a (x[i]),
         .b (y[i]),
         .c (1'b0),
         .d (cy[i]),
         .p (junk[2*i]),
         .q (junk[2*i+1]),
         .r (sum[i]),
         .s (cy[i+1])
      );
   end

   assign cout = cy[W];
endmodule

// File: rtl/mulred_tree.sv
module mulred_tree
   import mulred_pkg::*;
#(
   parameter int  N      = 4,
   localparam int LEVELS = $clog2(N),
   localparam int PW     = 2 * N,
   localparam int GW     = mulred_pkg::gb_off(N, $clog2(N))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      op_a,
   input  logic [N-1:0]      op_b,
   input  logic [LEVELS-1:0] lvl_en,
   output logic [PW-1:0]     product,
   output logic              product_valid,
   output logic [GW-1:0]     garbage
);
   if (N < 2 || (1 << LEVELS) != N) begin : g_bad
      $error("mulred_tree: N must be a power of two, at least 2");
   end

   // partial-product grid
   logic [N*N-1:0] rows;

   pp_gen #(.N(N)) u_pp (
      .a    (op_a),
      .b    (op_b),
      .rows (rows),
      .junk (garbage[2*N*N-1:0])
   );

   // reduction tree
   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int NN = nodes(N, l);
      localparam int WI = add_w(N, l);
      localparam int WO = out_w(N, l);
      localparam int S  = 1 << l;
      localparam int GN = node_gw(N, l);
      localparam int GO = gb_off(N, l);

      logic [2*NN*WI-1:0] src;
      logic [NN*WO-1:0]   nxt;
      logic [NN*WO-1:0]   node_q;

      if (l == 0) begin : g_leaf
         assign src = rows;
      end else begin : g_inner
         assign src = g_lvl[l-1].node_q;
      end

      for (genvar p = 0; p < NN; p++) begin : g_node
         logic [WI-1:0] x;
         logic [WI-1:0] y;
         logic [WI-1:0] xa;
         logic [WI-1:0] sum;
         logic          cout;

         assign x = src[2*p*WI +: WI];
         assign y = src[(2*p+1)*WI +: WI];

         // upper part of the even row lines up with the odd row
         always_comb begin
            xa = '0;
            xa[WI-S-1:0] = x[WI-1:S];
         end

         rev_ripple_add #(.W(WI)) u_add (
            .x    (xa),
            .y    (y),
            .sum  (sum),
            .cout (cout),
            .junk (garbage[GO+p*GN +: 2*WI])
         );

         if (l == 0) begin : g_keep
            assign nxt[p*WO +: WO] = {cout, sum, x[0]};
         end else begin : g_drop
            assign nxt[p*WO +: WO]       = {sum, x[S-1:0]};
            assign garbage[GO+p*GN+2*WI] = cout;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         node_q <= '0;
         else if (lvl_en[l]) node_q <= nxt;
      end
   end

   assign product = g_lvl[LEVELS-1].node_q;

   // freshness chain
   logic [PW-1:0]     prev_ops;
   logic              chg;
   logic [LEVELS-1:0] fresh;

   assign chg = ({op_a, op_b} != prev_ops);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ops <= '0;
         fresh    <= '0;
      end else begin
         prev_ops <= {op_a, op_b};
         fresh[0] <= lvl_en[0] | (fresh[0] & ~chg);
         for (int k = 1; k < LEVELS; k++) begin
            fresh[k] <= lvl_en[k] ? (fresh[k-1] & ~chg) : (fresh[k] & ~chg);
         end
      end
   end

   assign product_valid = fresh[LEVELS-1] & ~chg;
endmodule

// File: rtl/mulred_tree_chk.sv
module mulred_tree_chk #(
   parameter int N      = 4,
   parameter int LEVELS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      op_a,
   input logic [N-1:0]      op_b,
   input logic [LEVELS-1:0] lvl_en,
   input logic [2*N-1:0]    product,
   input logic              product_valid
);
   localparam int PW = 2 * N;

   // R1: reset clears outputs
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (product == '0 && !product_valid));

   // R2: valid implies exact product
   a_r2_valid_exact: assert property (@(posedge clk) disable iff (!rst_n)
      product_valid |-> (product == PW'(op_a) * PW'(op_b)));

   // R4: operand change drops valid at once
   a_r4_change_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
      ({op_a, op_b} != $past({op_a, op_b})) |-> !product_valid);

   // R5: last level off freezes product
   a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_en[LEVELS-1] |=> $stable(product));

   // R6: valid rises only right after the last level captured
   a_r6_rise_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(product_valid) |-> $past(lvl_en[LEVELS-1]));
endmodule

bind mulred_tree mulred_tree_chk #(.N(N), .LEVELS(LEVELS)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_a          (op_a),
   .op_b          (op_b),
   .lvl_en        (lvl_en),
   .product       (product),
   .product_valid (product_valid)
);

// File: tb/sim_mulred_tree.sv
module sim_mulred_tree;
   localparam int N  = 4;
   localparam int GW = mulred_pkg::gb_off(4, 2);

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  a, b;
   logic [1:0]    en;
   logic [7:0]    prod;
   logic          vld;
   logic [GW-1:0] gbus;

   int checks = 0;
   int errs   = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mulred_tree #(.N(N)) u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .op_a          (a),
      .op_b          (b),
      .lvl_en        (en),
      .product       (prod),
      .product_valid (vld),
      .garbage       (gbus)
   );

   // stand-alone cells for mapping checks
   logic [3:0] fa_in;
   logic       fp, fq, fr, fs;
   rev_fa_cell u_fa (.a(fa_in[3]), .b(fa_in[2]), .c(fa_in[1]), .d(fa_in[0]),
                     .p(fp), .q(fq), .r(fr), .s(fs));
   logic [2:0] sw_in;
   logic       sc, sq, sr;
   rev_swap_cell u_sw (.ctl(sw_in[2]), .x(sw_in[1]), .y(sw_in[0]),
                       .c_o(sc), .q_o(sq), .r_o(sr));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      chk(prod == 8'd0 && !vld, "R1 in reset", {prod, 7'd0, vld}, 64'd0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(!vld && prod == 8'd0, "R1 after release", {prod, 7'd0, vld}, 64'd0);
   endtask

   task automatic t_cells();
      logic [15:0] seen4;
      logic [7:0]  seen3;
      seen4 = '0;
      for (int v = 0; v < 16; v++) begin
         fa_in = 4'(v);
         #1;
         seen4[{fp, fq, fr, fs}] = 1'b1;
         if (fa_in[1] == 1'b0) begin
            logic ea, eb, ed;
            ea = fa_in[3]; eb = fa_in[2]; ed = fa_in[0];
            chk({fp, fq, fr, fs} == {ea, ea ^ eb, ea ^ eb ^ ed, (ea & eb) | (ed & (ea ^ eb))},
                "R7 full-adder mapping", {fp, fq, fr, fs},
                {ea, ea ^ eb, ea ^ eb ^ ed, (ea & eb) | (ed & (ea ^ eb))});
         end
      end
      chk(seen4 == 16'hFFFF, "R7 bijection", seen4, 16'hFFFF);
      seen3 = '0;
      for (int v = 0; v < 8; v++) begin
         sw_in = 3'(v);
         #1;
         seen3[{sc, sq, sr}] = 1'b1;
         chk({sc, sq, sr} == {sw_in[2], sw_in[2] ? sw_in[0] : sw_in[1], sw_in[2] ? sw_in[1] : sw_in[0]},
             "R8 swap mapping", {sc, sq, sr},
             {sw_in[2], sw_in[2] ? sw_in[0] : sw_in[1], sw_in[2] ? sw_in[1] : sw_in[0]});
         if (sw_in[0] == 1'b0)
            chk(sr == (sw_in[1] & sw_in[2]), "R8 AND output", sr, sw_in[1] & sw_in[2]);
      end
      chk(seen3 == 8'hFF, "R8 bijection", seen3, 8'hFF);
   endtask

   task automatic t_exhaustive();
      @(negedge clk) en = 2'b11;
      for (int ia = 0; ia < 16; ia++) begin
         for (int ib = 0; ib < 16; ib++) begin
            logic [7:0] e;
            e = 8'(ia * ib);
            @(negedge clk) begin a = 4'(ia); b = 4'(ib); end
            @(negedge clk);
            @(negedge clk);
            chk(vld && prod == e, "R2 product", {prod, 7'd0, vld}, {e, 8'd1});
         end
      end
   endtask

   task automatic t_latency();
      @(negedge clk) begin a = 4'd13; b = 4'd11; end
      #1 chk(!vld, "R4 same-cycle drop", vld, 0);
      @(negedge clk);
      chk(!vld, "R3 one edge", vld, 0);
      @(negedge clk);
      chk(vld && prod == 8'd143, "R3 two edges", {prod, 7'd0, vld}, {8'd143, 8'd1});
   endtask

   task automatic t_hold();
      @(negedge clk) begin en = 2'b11; a = 4'd3; b = 4'd5; end
      repeat (2) @(negedge clk);
      chk(vld && prod == 8'd15, "R5 setup", prod, 15);
      @(negedge clk) begin en = 2'b01; a = 4'd7; b = 4'd7; end
      repeat (3) @(negedge clk);
      chk(!vld && prod == 8'd15, "R5 last level frozen", {prod, 7'd0, vld}, {8'd15, 8'd0});
      en = 2'b11;
      @(negedge clk);
      chk(vld && prod == 8'd49, "R5 resume", {prod, 7'd0, vld}, {8'd49, 8'd1});
      en = 2'b10; a = 4'd2; b = 4'd2;
      repeat (2) @(negedge clk);
      chk(!vld && prod == 8'd49, "R5 first level frozen", {prod, 7'd0, vld}, {8'd49, 8'd0});
      en = 2'b11;
      repeat (2) @(negedge clk);
      chk(vld && prod == 8'd4, "R5 recover", {prod, 7'd0, vld}, {8'd4, 8'd1});
   endtask

   task automatic t_order();
      @(negedge clk) begin en = 2'b00; a = 4'd9; b = 4'd9; end
      @(negedge clk) en = 2'b10;
      @(negedge clk);
      chk(!vld && prod == 8'd4, "R6 last level first is stale", {prod, 7'd0, vld}, {8'd4, 8'd0});
      en = 2'b01;
      @(negedge clk);
      chk(!vld, "R6 first level only", vld, 0);
      en = 2'b10;
      @(negedge clk);
      chk(vld && prod == 8'd81, "R6 in-order completion", {prod, 7'd0, vld}, {8'd81, 8'd1});
   endtask

   task automatic t_garbage();
      logic [31:0] e;
      @(negedge clk) begin a = 4'b1010; b = 4'b0110; end
      #1;
      for (int j = 0; j < N; j++) begin
         for (int i = 0; i < N; i++) begin
            e[2*(j*N+i)]   = b[j];
            e[2*(j*N+i)+1] = a[i] & ~b[j];
         end
      end
      chk(gbus[31:0] == e, "R9 swap-grid garbage", gbus[31:0], e);
   endtask

   initial begin
      rst_n = 1'b0; a = '0; b = '0; en = 2'b00; fa_in = '0; sw_in = '0;
      repeat (3) @(negedge clk);
      t_reset();
      t_cells();
      t_exhaustive();
      t_latency();
      t_hold();
      t_order();
      t_garbage();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errs++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errs);
         $finish;
      end
   end
endmodule